// File: doc/BRIEF.md
# I2C Byte Master with Register Port

This block is an I2C bus master that a processor drives through four word registers. Software loads a clock divider and an enable bit, places a byte in the data register and writes one command byte. The command byte can combine a START (or repeated START), a byte write or a byte read, the acknowledge value to return on a read, and a trailing STOP. The block then runs the whole byte on the open-drain clock and data lines and reports the result in a status word that shares its address with the command register. The receive byte shares its address with the transmit byte.

Each bit on the wire takes four quarter-periods of (divider + 1) system clocks. Data changes only while the clock line is held low. The bus inputs pass through a synchronizer. A bus monitor uses them to follow START and STOP conditions and to spot a lost arbitration, which aborts the byte and frees both lines.

The register port has no back-pressure signal. A register write lands in one cycle. A command write is taken only while the core is enabled and no transfer is in progress, so software polls the in-progress flag, or waits for the interrupt, before it issues the next command.

Top module: `i2c_host_ctrl`

## Requirements
- R1: After reset the divider register (offset 0) reads 0xFFFF, and the control (offset 1), receive (offset 2) and status (offset 3) registers read 0.
- R2: Writes to offset 1 set control bit 7 (core enable) and bit 6 (interrupt enable), and reads return the value written. Writes to offset 2 load the transmit byte. Writes to offset 3 are commands: bit 7 START, bit 6 STOP, bit 5 READ, bit 4 WRITE, bit 3 acknowledge value, bit 0 interrupt acknowledge.
- R3: A command with START and WRITE sends a START (a repeated START if the bus is already held), then the transmit byte MSB first. The level sampled in the acknowledge slot is stored in status bit 7 (1 = not acknowledged).
- R4: A READ command shifts eight bits MSB first into the receive register. In the acknowledge slot the master drives command bit 3: 0 pulls the line low (ACK), 1 leaves it released (NACK).
- R5: STOP in a command appends a STOP condition after the acknowledge slot. A STOP alone issues only the STOP. Status bit 6 (bus busy) sets when a START is seen on the lines and clears when a STOP is seen.
- R6: Status bit 1 (transfer in progress) is 1 from the cycle after the command is taken until the byte, its acknowledge slot and any STOP have finished. The command bits then clear themselves.
- R7: Status bit 0 (interrupt flag) sets when a command completes or arbitration is lost. Writing command bit 0 clears it. The irq output equals the flag ANDed with control bit 6.
- R8: The clock line stays high for exactly 2 × (divider + 1) system clocks per bit. During data and acknowledge bits the data line changes only while the clock line is low.
- R9: When the master releases the data line to send a 1 but samples it low, it aborts the byte, releases both lines and sets status bit 5 (arbitration lost) and the interrupt flag. An unrequested STOP seen during a transfer has the same effect. Status bit 5 clears when the next command is taken.
- R10: While control bit 7 is 0, command writes are ignored: no transfer starts, the in-progress flag stays 0 and both lines stay released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_en | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | Word offset of the register |
| reg_wdata | input | PW (16) | Write data |
| reg_rdata | output | PW (16) | Read data, driven combinationally from reg_addr |
| irq | output | 1 | Interrupt request |
| scl_i | input | 1 | Clock line level sensed on the bus |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_i | input | 1 | Data line level sensed on the bus |
| sda_oe | output | 1 | 1 pulls the data line low |

## Verification
The assertions check on every cycle that the sequencer never works outside the in-progress window, that the interrupt flag rises only at the end of a transfer, that the data line moves under a high clock only inside START, STOP or an abort, that an abort frees both lines, and that no transfer starts while the core is disabled. Only the bench scenarios, run against a behavioural slave on the wired-AND bus, can show the bit order on the wire, the acknowledge values in both directions, repeated START, the clock-high width for random divider values, bus-busy tracking and the full arbitration-loss recovery.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [1:0] {BC_START, BC_STOP, BC_WRITE, BC_READ} bit_cmd_e;

  localparam logic [1:0] A_PRE = 2'd0;
  localparam logic [1:0] A_CTL = 2'd1;
  localparam logic [1:0] A_DAT = 2'd2;
  localparam logic [1:0] A_CMD = 2'd3;

  // command byte fields
  localparam int C_STA  = 7;
  localparam int C_STO  = 6;
  localparam int C_RD   = 5;
  localparam int C_WR   = 4;
  localparam int C_ACK  = 3;
  localparam int C_IACK = 0;

  // control byte fields
  localparam int K_EN  = 7;
  localparam int K_IEN = 6;
endpackage

// File: rtl/i2cm_bit_engine.sv
module i2cm_bit_engine
  import i2cm_pkg::*;
#(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] prescale,
  input  logic          go,
  input  bit_cmd_e      cmd,
  input  logic          din,
  input  logic          abort,
  input  logic          sda_s,
  output logic          active,
  output logic          done,
  output logic          al,
  output logic          rx_bit,
  output logic          scl_oe,
  output logic          sda_oe
);
  logic [PW-1:0] cnt;
  logic [1:0]    phase;
  bit_cmd_e      cmd_q;
  logic          din_q;

  // {scl_oe, sda_oe} for each quarter of a bit; 1 pulls a line low
  function automatic logic [1:0] drive(bit_cmd_e c, logic [1:0] ph, logic d);
    case (c)
      BC_START: case (ph)
        2'd0:    return 2'b10;
        2'd1:    return 2'b00;
        2'd2:    return 2'b01;
        default: return 2'b11;
      endcase
      BC_STOP: case (ph)
        2'd0:    return 2'b11;
        2'd1:    return 2'b01;
        default: return 2'b00;
      endcase
      default: return {(ph == 2'd0) || (ph == 2'd3), ~d};
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; done <= 1'b0; al <= 1'b0; rx_bit <= 1'b0;
      scl_oe <= 1'b0; sda_oe <= 1'b0; cnt <= '0; phase <= '0;
      cmd_q  <= BC_STOP; din_q <= 1'b1;
    end else begin
      done <= 1'b0;
      al   <= 1'b0;
      if (abort) begin
        active <= 1'b0; scl_oe <= 1'b0; sda_oe <= 1'b0;
      end else if (go) begin
        active <= 1'b1; cmd_q <= cmd; din_q <= din; phase <= 2'd0; cnt <= prescale;
        {scl_oe, sda_oe} <= drive(cmd, 2'd0, din);
      end else if (active) begin
        if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end else if (phase == 2'd2 && cmd_q == BC_WRITE && din_q && !sda_s) begin
          al <= 1'b1; active <= 1'b0; scl_oe <= 1'b0; sda_oe <= 1'b0;
        end else begin
          if (phase == 2'd2) rx_bit <= sda_s;
          if (phase == 2'd3) begin
            active <= 1'b0; done <= 1'b1;
          end else begin
            phase <= phase + 2'd1;
            cnt   <= prescale;
            {scl_oe, sda_oe} <= drive(cmd_q, phase + 2'd1, din_q);
          end
        end
      end
    end
  end

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !scl_oe && !$past(scl_oe)) |->
      (cmd_q == BC_START || cmd_q == BC_STOP || $past(abort) || $past(al))); // R8

  AST_ABORT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!scl_oe && !sda_oe)); // R9
endmodule

// File: rtl/i2cm_byte_seq.sv
module i2cm_byte_seq
  import i2cm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [4:0] cmd_hi,     // command byte bits 7..3
  input  logic [7:0] tx_byte,
  input  logic       abort,
  input  logic       eng_active,
  input  logic       eng_done,
  input  logic       eng_rx,
  output logic       bit_go,
  output bit_cmd_e   bit_cmd,
  output logic       bit_din,
  output logic       busy,
  output logic       fin,
  output logic [7:0] rx_byte,
  output logic       rx_ack
);
  typedef enum logic [2:0] {S_IDLE, S_START, S_BIT, S_ACK, S_STOP} seq_e;
  seq_e       state;
  logic       sto_q, rd_q, wr_q, ack_q;
  logic [7:0] sh;
  logic [2:0] bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; sto_q <= 1'b0; rd_q <= 1'b0; wr_q <= 1'b0; ack_q <= 1'b0;
      sh <= '0; bcnt <= '0; bit_go <= 1'b0; fin <= 1'b0; rx_byte <= '0; rx_ack <= 1'b0;
    end else begin
      bit_go <= 1'b0;
      fin    <= 1'b0;
      if (abort) begin
        state <= S_IDLE;
      end else begin
        case (state)
          S_IDLE: if (start) begin
            sto_q <= cmd_hi[C_STO-3]; rd_q <= cmd_hi[C_RD-3];
            wr_q  <= cmd_hi[C_WR-3];  ack_q <= cmd_hi[C_ACK-3];
            sh <= tx_byte; bcnt <= '0;
            if (cmd_hi[C_STA-3])                         begin state <= S_START; bit_go <= 1'b1; end
            else if (cmd_hi[C_RD-3] || cmd_hi[C_WR-3])   begin state <= S_BIT;   bit_go <= 1'b1; end
            else if (cmd_hi[C_STO-3])                    begin state <= S_STOP;  bit_go <= 1'b1; end
            else fin <= 1'b1;
          end
          S_START: if (eng_done) begin
            if (rd_q || wr_q) begin state <= S_BIT;  bit_go <= 1'b1; end
            else if (sto_q)   begin state <= S_STOP; bit_go <= 1'b1; end
            else begin state <= S_IDLE; fin <= 1'b1; end
          end
          S_BIT: if (eng_done) begin
            sh     <= {sh[6:0], eng_rx};
            bcnt   <= bcnt + 3'd1;
            bit_go <= 1'b1;
            if (bcnt == 3'd7) state <= S_ACK;
          end
          S_ACK: if (eng_done) begin
            if (wr_q) rx_ack  <= eng_rx;
            else      rx_byte <= sh;
            if (sto_q) begin state <= S_STOP; bit_go <= 1'b1; end
            else begin state <= S_IDLE; fin <= 1'b1; end
          end
          S_STOP: if (eng_done) begin state <= S_IDLE; fin <= 1'b1; end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    bit_cmd = BC_STOP;
    bit_din = 1'b1;
    case (state)
      S_START: bit_cmd = BC_START;
      S_BIT:   begin bit_cmd = wr_q ? BC_WRITE : BC_READ;  bit_din = wr_q ? sh[7] : 1'b1; end
      S_ACK:   begin bit_cmd = wr_q ? BC_READ  : BC_WRITE; bit_din = wr_q ? 1'b1 : ack_q; end
      default: bit_cmd = BC_STOP;
    endcase
  end

  assign busy = (state != S_IDLE);

  AST_GO_ENGINE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_go |-> !eng_active); // R3
endmodule

// File: rtl/i2c_host_ctrl.sv
module i2c_host_ctrl
  import i2cm_pkg::*;
#(
  parameter int PW   = 16,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_en,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [PW-1:0] reg_wdata,
  output logic [PW-1:0] reg_rdata,
  output logic          irq,
  input  logic          scl_i,
  output logic          scl_oe,
  input  logic          sda_i,
  output logic          sda_oe
);
  logic [PW-1:0]   pre_q;
  logic [7:0]      ctl_q, tx_q, status;
  logic [3:0]      cmd_q;
  logic            if_q, al_q, busy_q, tip;
  logic [SYNC-1:0] scl_sy, sda_sy;
  logic            scl_d, sda_d, scl_s, sda_s, start_det, stop_det;
  logic            wr_hit, cmd_go, al_evt;
  logic            eng_active, eng_done, eng_al, eng_rx;
  logic            bit_go, bit_din, seq_busy, fin, rx_ack;
  bit_cmd_e        bit_cmd;
  logic [7:0]      rx_byte;

  // bus input synchronizer and condition detector
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '1; sda_sy <= '1; scl_d <= 1'b1; sda_d <= 1'b1; busy_q <= 1'b0;
    end else begin
      scl_sy <= {scl_sy[SYNC-2:0], scl_i};
      sda_sy <= {sda_sy[SYNC-2:0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
      if (start_det)     busy_q <= 1'b1;
      else if (stop_det) busy_q <= 1'b0;
    end
  end
  assign scl_s     = scl_sy[SYNC-1];
  assign sda_s     = sda_sy[SYNC-1];
  assign start_det = scl_d && scl_s && sda_d && !sda_s;
  assign stop_det  = scl_d && scl_s && !sda_d && sda_s;

  assign wr_hit = reg_en && reg_wr;
  assign tip    = |cmd_q;
  assign cmd_go = wr_hit && reg_addr == A_CMD && ctl_q[K_EN] && !tip && |reg_wdata[7:4];
  assign al_evt = eng_al || (stop_det && seq_busy && bit_cmd != BC_STOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '1; ctl_q <= '0; tx_q <= '0; cmd_q <= '0; if_q <= 1'b0; al_q <= 1'b0;
    end else begin
      if (wr_hit && reg_addr == A_PRE) pre_q <= reg_wdata;
      if (wr_hit && reg_addr == A_CTL) ctl_q <= reg_wdata[7:0];
      if (wr_hit && reg_addr == A_DAT) tx_q  <= reg_wdata[7:0];
      if (cmd_go)             cmd_q <= reg_wdata[7:4];
      else if (fin || al_evt) cmd_q <= '0;
      if (al_evt)      al_q <= 1'b1;
      else if (cmd_go) al_q <= 1'b0;
      if (fin || al_evt) if_q <= 1'b1;
      else if (wr_hit && reg_addr == A_CMD && reg_wdata[C_IACK]) if_q <= 1'b0;
    end
  end

  assign status = {rx_ack, busy_q, al_q, 3'b000, tip, if_q};
  assign irq    = if_q && ctl_q[K_IEN];

  always_comb begin
    case (reg_addr)
      A_PRE:   reg_rdata = pre_q;
      A_CTL:   reg_rdata = PW'(ctl_q);
      A_DAT:   reg_rdata = PW'(rx_byte);
      default: reg_rdata = PW'(status);
    endcase
  end

  i2cm_byte_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(cmd_go), .cmd_hi(reg_wdata[7:3]), .tx_byte(tx_q),
    .abort(al_evt), .eng_active(eng_active), .eng_done(eng_done), .eng_rx(eng_rx),
    .bit_go(bit_go), .bit_cmd(bit_cmd), .bit_din(bit_din), .busy(seq_busy), .fin(fin),
    .rx_byte(rx_byte), .rx_ack(rx_ack)
  );

  i2cm_bit_engine #(.PW(PW)) u_eng (
    .clk(clk), .rst_n(rst_n), .prescale(pre_q), .go(bit_go), .cmd(bit_cmd), .din(bit_din),
    .abort(al_evt), .sda_s(sda_s), .active(eng_active), .done(eng_done), .al(eng_al),
    .rx_bit(eng_rx), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  AST_TIP_COVERS_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy |-> tip); // R6

  AST_IF_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(if_q) |-> $past(tip)); // R7

  AST_NO_CMD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tip) |-> $past(ctl_q[K_EN])); // R10
endmodule

// File: tb/sim_i2c_host_ctrl.sv
module sim_i2c_host_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_en = 1'b0, reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq, scl_oe, sda_oe;
  logic        scl_line, sda_line;
  logic        slv_oe = 1'b0, force_low = 1'b0;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign scl_line = ~scl_oe;
  assign sda_line = ~(sda_oe | slv_oe | force_low);

  i2c_host_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_i(scl_line), .scl_oe(scl_oe), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  // behavioural slave: 0 idle, 1 address, 2 write data, 3 read data
  int         mode = 0, nmode = 0, bitc = 0;
  logic [7:0] shreg = '0, rd_byte = '0, last_wr = '0, addr_seen = '0;
  logic       ack_en = 1'b1, mack = 1'b0, p_scl = 1'b1, p_sda = 1'b1;

  always @(scl_line or sda_line) begin
    if (scl_line && p_scl && p_sda && !sda_line) begin
      mode = 1; bitc = 0; slv_oe = 1'b0;
    end else if (scl_line && p_scl && !p_sda && sda_line) begin
      mode = 0; bitc = 0; slv_oe = 1'b0;
    end else if (scl_line && !p_scl) begin
      if (mode != 0) begin
        if (bitc < 8 && mode != 3) shreg = {shreg[6:0], sda_line};
        if (bitc == 8 && mode == 3) mack = sda_line;
        bitc++;
      end
    end else if (!scl_line && p_scl) begin
      if (mode != 0) begin
        if (bitc == 8) begin
          if (mode != 3) begin
            slv_oe = ack_en;
            if (mode == 1) begin addr_seen = shreg; nmode = shreg[0] ? 3 : 2; end
            else begin last_wr = shreg; nmode = 2; end
          end else begin
            slv_oe = 1'b0; nmode = 3;
          end
        end else if (bitc == 9) begin
          bitc = 0;
          if (mode == 3 && mack) mode = 0; else mode = nmode;
          slv_oe = (mode == 3) ? ~rd_byte[7] : 1'b0;
        end else if (mode == 3 && bitc >= 1 && bitc < 8) begin
          slv_oe = ~rd_byte[7-bitc];
        end
      end
    end
    p_scl = scl_line;
    p_sda = sda_line;
  end

  // clock-high run length monitor (sampled away from the active edge)
  int run = 0, last_run = 0;
  always @(negedge clk) begin
    if (scl_line) run++;
    else begin
      if (run != 0) last_run = run;
      run = 0;
    end
  end

  function automatic logic [7:0] exp_st(bit rxack, bit busy, bit al, bit tip, bit iflag);
    return {rxack, busy, al, 3'b000, tip, iflag};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wait_tip();
    logic [15:0] s;
    for (int g = 0; g < 5000; g++) begin
      rd(2'd3, s);
      if (!s[1]) break;
    end
  endtask

  task automatic cmd_wait(input logic [7:0] c);
    logic [15:0] s;
    wr(2'd3, {8'h00, c});
    rd(2'd3, s);
    chk("R6 tip set after command", int'(s[1]), 1);
    wait_tip();
  endtask

  task automatic iack();
    wr(2'd3, 16'h0001);
  endtask

  initial begin
    logic [15:0] v;
    logic [7:0]  d, rb;
    int          p, seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    rd(2'd0, v); chk("R1 divider reset", int'(v), 16'hFFFF);
    rd(2'd1, v); chk("R1 control reset", int'(v), 0);
    rd(2'd2, v); chk("R1 receive reset", int'(v), 0);
    rd(2'd3, v); chk("R1 status reset", int'(v), 0);

    // R10: core disabled, command ignored
    wr(2'd0, 16'd3);
    wr(2'd2, 16'h00A0);
    wr(2'd3, 16'h0090);
    repeat (20) @(negedge clk);
    rd(2'd3, v); chk("R10 status stays idle", int'(v), 0);
    chk("R10 lines released", int'({scl_oe, sda_oe}), 0);

    wr(2'd1, 16'h00C0);
    rd(2'd1, v); chk("R2 control readback", int'(v), 16'h00C0);
    rd(2'd0, v); chk("R2 divider readback", int'(v), 3);

    for (int it = 0; it < 6; it++) begin
      p  = 2 + int'($urandom % 5);
      d  = 8'($urandom);
      rb = 8'($urandom);
      wr(2'd0, 16'(p));
      rd_byte = rb;
      // address for write
      wr(2'd2, 16'h00A0);
      cmd_wait(8'h90);
      rd(2'd3, v); chk("R3 addr acked, busy, IF", int'(v), int'(exp_st(0, 1, 0, 0, 1)));
      chk("R3 address on wire", int'(addr_seen), 8'hA0);
      chk("R7 irq with IF and enable", int'(irq), 1);
      iack();
      rd(2'd3, v); chk("R7 IF cleared by acknowledge", int'(v), int'(exp_st(0, 1, 0, 0, 0)));
      chk("R7 irq low after acknowledge", int'(irq), 0);
      // data byte with stop
      wr(2'd2, {8'h00, d});
      cmd_wait(8'h50);
      chk("R3 data byte MSB first", int'(last_wr), int'(d));
      chk("R8 clock high width", last_run, 2 * (p + 1));
      rd(2'd3, v); chk("R5 stop clears busy", int'(v), int'(exp_st(0, 0, 0, 0, 1)));
      iack();
      // address for read
      wr(2'd2, 16'h00A1);
      cmd_wait(8'h90);
      iack();
      // first read with ACK
      cmd_wait(8'h20);
      rd(2'd2, v); chk("R4 read byte (ACK)", int'(v), int'(rb));
      chk("R4 master ACK drives 0", int'(mack), 0);
      iack();
      // second read with NACK and stop
      cmd_wait(8'h68);
      rd(2'd2, v); chk("R4 read byte (NACK)", int'(v), int'(rb));
      chk("R4 master NACK leaves 1", int'(mack), 1);
      rd(2'd3, v); chk("R5 read with stop ends idle", int'(v), int'(exp_st(0, 0, 0, 0, 1)));
      iack();
    end

    // R3: no acknowledge from slave
    wr(2'd0, 16'd3);
    ack_en = 1'b0;
    wr(2'd2, 16'h00A0);
    cmd_wait(8'h90);
    rd(2'd3, v); chk("R3 NACK in status bit 7", int'(v), int'(exp_st(1, 1, 0, 0, 1)));
    iack();
    ack_en = 1'b1;
    cmd_wait(8'h40);
    rd(2'd3, v); chk("R5 stop-only command", int'(v), int'(exp_st(1, 0, 0, 0, 1)));
    iack();

    // R3/R5: repeated start keeps the bus busy
    wr(2'd2, 16'h00A0);
    cmd_wait(8'h90);
    iack();
    wr(2'd2, 16'h00B4);
    cmd_wait(8'h90);
    chk("R3 repeated start address", int'(addr_seen), 8'hB4);
    rd(2'd3, v); chk("R5 busy through repeated start", int'(v), int'(exp_st(0, 1, 0, 0, 1)));
    iack();
    cmd_wait(8'h40);
    iack();

    // R9: arbitration loss
    cmd_wait(8'h80);
    iack();
    force_low = 1'b1;
    wr(2'd2, 16'h00FF);
    cmd_wait(8'h10);
    rd(2'd3, v); chk("R9 arbitration lost status", int'(v), int'(exp_st(0, 1, 1, 0, 1)));
    chk("R9 lines released", int'({scl_oe, sda_oe}), 0);
    chk("R7 irq on arbitration loss", int'(irq), 1);
    force_low = 1'b0;
    repeat (10) @(negedge clk);
    rd(2'd3, v); chk("R5 foreign stop clears busy", int'(v), int'(exp_st(0, 0, 1, 0, 1)));
    iack();
    wr(2'd2, 16'h00A0);
    cmd_wait(8'h90);
    rd(2'd3, v); chk("R9 lost flag cleared by new command", int'(v), int'(exp_st(0, 1, 0, 0, 1)));
    iack();
    cmd_wait(8'h40);

    // R10: disable again
    wr(2'd1, 16'h0000);
    wr(2'd3, 16'h0090);
    repeat (5) @(negedge clk);
    rd(2'd3, v); chk("R10 no transfer when disabled", int'(v[1]), 0);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule